// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits on the controller side of an asynchronous page-mode DRAM. It moves the memory into self refresh and brings it back out by driving only the row and column strobes. A standby request from the system first takes ownership of the memory from the normal-access engine through a request/grant handshake. Once the grant arrives, the block runs a complete burst of CAS-before-RAS refresh cycles. It then pulls CAS low, pulls RAS low after it, and holds both low. After the minimum hold has elapsed, the DRAM refreshes itself. The controller does not touch the strobes again until an exit is requested.

On exit, both strobes rise together and RAS is held high for the precharge minimum. A second full refresh burst follows. The block then pulses `ready` for one cycle and releases the memory back to normal access. Every interval is given in nanoseconds and converted at elaboration into whole clock cycles, rounded up. An exit request that comes early is remembered and carried out as soon as the minimum hold has elapsed.

Top module: `sr_seq`

## Requirements
- R1: While reset is asserted and right after it, `ras_n` and `cas_n` are high, and `busy`, `ready` and `arb_req` are low.
- R2: In the idle state, `arb_req` follows `sr_enter_req` in the same cycle. No strobe moves until `arb_gnt` is seen together with `sr_enter_req`. The first refresh pulse starts in the cycle after that edge, far inside the 2 ms allowed gap.
- R3: Each refresh burst has exactly BURST_LEN pulses. Each pulse is CSR_CYC cycles with only CAS low, then RAS_CYC cycles with both low, then RP_CYC cycles with both high. RAS is never low while CAS is high.
- R4: After the pre-entry burst, CAS alone goes low for CSR_CYC cycles before RAS goes low.
- R5: Both strobes stay low for at least HOLD_CYC cycles. An exit request seen before the hold ends is latched, and the exit begins after exactly HOLD_CYC + 1 low cycles.
- R6: While self refresh is active, neither strobe changes.
- R7: On exit, RAS and CAS rise on the same edge. RAS then stays high for exactly PRECH_CYC cycles before the next CAS fall.
- R8: After the post-exit burst of BURST_LEN pulses, `ready` is high for exactly one cycle with `busy` low, and `arb_req` drops.
- R9: `busy` is high in every state except idle and the one-cycle ready state.
- R10: An exit request while idle, and any request after the exit has begun, leave the outputs unchanged. An enter request while busy is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_enter_req | input | 1 | Level request to enter standby self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh (pulse or level) |
| arb_req | output | 1 | Ownership request to the normal-access engine |
| arb_gnt | input | 1 | Grant from the normal-access engine |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle pulse: sequence finished, access may resume |

## Verification
Two standby periods are run, and a cycle-accurate reference model is compared with the outputs on every clock.

The first period delays the grant by ten cycles and issues the exit request during the pre-entry burst. This separates a latched early exit, which gives a hold of exactly HOLD_CYC + 1 cycles, from an exit that is dropped or acted on too early. The second period grants at once and exits long after the hold has ended. This exposes any strobe movement during self refresh.

Stray exit requests while idle and during the exit precharge, and a stray enter request while busy, show whether requests are gated by state. Port monitors count the refresh pulses in each burst and measure the hold and precharge lengths.

// File: rtl/sr_pkg.sv
// Shared types and elaboration helpers for the self-refresh sequencer.
// Assumes all times are given in ns and the clock period in ps.
package sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_BURST,
        ST_ENTER_CBR,
        ST_HOLD,
        ST_SELF,
        ST_EXIT_PRE,
        ST_POST_BURST,
        ST_READY
    } sr_state_e;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_CSR,
        BP_RAS,
        BP_PRE
    } burst_phase_e;

    // Ceiling conversion of a time in ns to clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input longint unsigned t_ns,
                                                 input longint unsigned clk_ps);
        longint unsigned c;
        c = (t_ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

    // Largest of three cycle counts, used to size shared counters.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sr_interval_timer.sv
// Loadable down-counter: after a load of N it reports expiry in the N-th cycle.
// Assumes load_val >= 1 and that a load is not issued while a count is running.
module sr_interval_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;
    logic         run;

    // Count down from the loaded value; stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= load_val - W'(1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - W'(1);
        end
    end

    // Expiry flag for the final cycle of the interval.
    always_comb expired = run && (cnt == '0);

    // R5: no reload lands on a running count (interval would be cut short).
    p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!run || expired));

endmodule

// File: rtl/sr_cbr_burst.sv
// Issues a burst of BURST_LEN CAS-before-RAS refresh pulses on a start pulse.
// Each pulse is CSR_CYC cycles of CAS only, RAS_CYC of both low, RP_CYC both high.
// Assumes start only arrives while no burst is running.
module sr_cbr_burst import sr_pkg::*; #(
    parameter int unsigned BURST_LEN = 2048,
    parameter int unsigned CSR_CYC   = 2,
    parameter int unsigned RAS_CYC   = 14,
    parameter int unsigned RP_CYC    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ras_n,
    output logic cas_n,
    output logic done
);

    localparam int unsigned PW   = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
    localparam int unsigned CMAX = max3(CSR_CYC, RAS_CYC, RP_CYC);
    localparam int unsigned CW   = $clog2(CMAX + 1);

    burst_phase_e  phase;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic          last_pulse;

    always_comb last_pulse = (pcnt == PW'(BURST_LEN - 1));

    // Walk each pulse through its three phases and count pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= BP_IDLE;
            cnt   <= '0;
            pcnt  <= '0;
        end else begin
            case (phase)
                BP_IDLE: if (start) begin
                    phase <= BP_CSR;
                    cnt   <= CW'(CSR_CYC - 1);
                    pcnt  <= '0;
                end
                BP_CSR: if (cnt == '0) begin
                    phase <= BP_RAS;
                    cnt   <= CW'(RAS_CYC - 1);
                end else cnt <= cnt - CW'(1);
                BP_RAS: if (cnt == '0) begin
                    phase <= BP_PRE;
                    cnt   <= CW'(RP_CYC - 1);
                end else cnt <= cnt - CW'(1);
                default: if (cnt == '0) begin
                    if (last_pulse) begin
                        phase <= BP_IDLE;
                    end else begin
                        phase <= BP_CSR;
                        cnt   <= CW'(CSR_CYC - 1);
                        pcnt  <= pcnt + PW'(1);
                    end
                end else cnt <= cnt - CW'(1);
            endcase
        end
    end

    // Strobe decode and end-of-burst flag.
    always_comb begin
        cas_n = !((phase == BP_CSR) || (phase == BP_RAS));
        ras_n = !(phase == BP_RAS);
        done  = (phase == BP_PRE) && (cnt == '0) && last_pulse;
    end

    // R3: RAS only falls after CAS was already low in the previous cycle.
    p_cas_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R3: a new burst never starts on top of a running one.
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase == BP_IDLE));

endmodule

// File: rtl/sr_seq.sv
// Self-refresh entry/exit sequencer for an asynchronous page-mode DRAM.
// Takes ownership by request/grant, runs a refresh burst, enters self refresh
// with CAS before RAS, holds, exits with a RAS precharge, runs a second burst.
// Assumes times are in ns and the clock period in ps; strobes are active low.
module sr_seq import sr_pkg::*; #(
    parameter int unsigned CLK_PS       = 5000,
    parameter int unsigned HOLD_NS      = 100000,
    parameter int unsigned PRECH_NS     = 124,
    parameter int unsigned CSR_NS       = 10,
    parameter int unsigned BURST_RAS_NS = 70,
    parameter int unsigned BURST_RP_NS  = 50,
    parameter int unsigned BURST_LEN    = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    output logic arb_req,
    input  logic arb_gnt,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic ready
);

    localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_PS);
    localparam int unsigned PRECH_CYC = ns_to_cycles(PRECH_NS, CLK_PS);
    localparam int unsigned CSR_CYC   = ns_to_cycles(CSR_NS, CLK_PS);
    localparam int unsigned RAS_CYC   = ns_to_cycles(BURST_RAS_NS, CLK_PS);
    localparam int unsigned RP_CYC    = ns_to_cycles(BURST_RP_NS, CLK_PS);
    localparam int unsigned TMR_MAX   = max3(HOLD_CYC, PRECH_CYC, CSR_CYC);
    localparam int unsigned TW        = $clog2(TMR_MAX + 1);
    localparam int unsigned FW        = $clog2(BURST_LEN + 1);

    sr_state_e     state, nxt;
    logic          exit_pend, go_exit;
    logic          b_start, b_done, b_ras_n, b_cas_n;
    logic          t_load, t_exp;
    logic [TW-1:0] t_val;

    sr_cbr_burst #(
        .BURST_LEN (BURST_LEN),
        .CSR_CYC   (CSR_CYC),
        .RAS_CYC   (RAS_CYC),
        .RP_CYC    (RP_CYC)
    ) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (b_start),
        .ras_n (b_ras_n),
        .cas_n (b_cas_n),
        .done  (b_done)
    );

    sr_interval_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    // Exit may begin only from the self state, on a pending or fresh request.
    always_comb go_exit = (state == ST_SELF) && (exit_pend || sr_exit_req);

    // Next-state, timer load and burst start selection.
    always_comb begin
        nxt     = state;
        t_load  = 1'b0;
        t_val   = '0;
        b_start = 1'b0;
        case (state)
            ST_IDLE: if (sr_enter_req && arb_gnt) begin
                nxt     = ST_PRE_BURST;
                b_start = 1'b1;
            end
            ST_PRE_BURST: if (b_done) begin
                nxt    = ST_ENTER_CBR;
                t_load = 1'b1;
                t_val  = TW'(CSR_CYC);
            end
            ST_ENTER_CBR: if (t_exp) begin
                nxt    = ST_HOLD;
                t_load = 1'b1;
                t_val  = TW'(HOLD_CYC);
            end
            ST_HOLD: if (t_exp) nxt = ST_SELF;
            ST_SELF: if (go_exit) begin
                nxt    = ST_EXIT_PRE;
                t_load = 1'b1;
                t_val  = TW'(PRECH_CYC);
            end
            ST_EXIT_PRE: if (t_exp) begin
                nxt     = ST_POST_BURST;
                b_start = 1'b1;
            end
            ST_POST_BURST: if (b_done) nxt = ST_READY;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Remember an exit request that arrives before self refresh is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exit_pend <= 1'b0;
        else if (go_exit)
            exit_pend <= 1'b0;
        else if (sr_exit_req && (state inside {ST_PRE_BURST, ST_ENTER_CBR, ST_HOLD}))
            exit_pend <= 1'b1;
    end

    // Strobe and status decode.
    always_comb begin
        case (state)
            ST_PRE_BURST, ST_POST_BURST: begin ras_n = b_ras_n; cas_n = b_cas_n; end
            ST_ENTER_CBR:                begin ras_n = 1'b1;    cas_n = 1'b0;    end
            ST_HOLD, ST_SELF:            begin ras_n = 1'b0;    cas_n = 1'b0;    end
            default:                     begin ras_n = 1'b1;    cas_n = 1'b1;    end
        endcase
        busy    = !((state == ST_IDLE) || (state == ST_READY));
        ready   = (state == ST_READY);
        arb_req = busy || ((state == ST_IDLE) && sr_enter_req);
    end

    // ---------------- checker state and assertions ----------------
    logic          ras_q;
    logic [TW-1:0] low_run, hi_run;
    logic [FW-1:0] burst_falls;

    // Run lengths of RAS low/high and refresh pulses per burst, for checking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q       <= 1'b1;
            low_run     <= '0;
            hi_run      <= '0;
            burst_falls <= '0;
        end else begin
            ras_q   <= ras_n;
            low_run <= ras_n ? '0 : ((low_run == TW'(TMR_MAX)) ? low_run : low_run + TW'(1));
            hi_run  <= !ras_n ? '0 : ((hi_run == TW'(TMR_MAX)) ? hi_run : hi_run + TW'(1));
            if (b_start)
                burst_falls <= '0;
            else if (ras_q && !ras_n && (state inside {ST_PRE_BURST, ST_POST_BURST}))
                burst_falls <= burst_falls + FW'(1);
        end
    end

    // R3: a finished burst contains exactly BURST_LEN RAS pulses.
    p_burst_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        b_done |-> (burst_falls == FW'(BURST_LEN)));

    // R3: RAS never low while CAS is high (CBR only).
    p_cbr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R2: strobes only move while the memory is owned.
    p_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> arb_req);

    // R5: self refresh is only reached after the full low hold.
    p_hold_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELF) |-> (low_run >= TW'(HOLD_CYC)));

    // R6: strobes are frozen while self refresh persists.
    p_self_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELF && $past(state) == ST_SELF) |-> ($stable(ras_n) && $stable(cas_n)));

    // R7: both strobes rise together.
    p_rise_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $rose(cas_n));

    // R7: precharge length before the post-exit burst.
    p_prech_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_EXIT_PRE && state == ST_POST_BURST) |-> (hi_run >= TW'(PRECH_CYC)));

    // R8: ready is a single-cycle pulse followed by a free state.
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (!ready && !busy));

endmodule

// File: tb/sim_sr_seq.sv
`timescale 1ns/1ps
// Bench for sr_seq: behavioural queue model compared every cycle plus port monitors.
module sim_sr_seq;

    localparam int B      = 2048;
    localparam int CSR    = 1;
    localparam int RASC   = 2;
    localparam int RPC    = 1;
    localparam int HOLD   = 20000;
    localparam int PRECH  = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter = 1'b0, exitr = 1'b0, gnt = 1'b0;
    logic arb_req, ras_n, cas_n, busy, ready;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    sr_seq #(
        .CLK_PS(5000), .HOLD_NS(100000), .PRECH_NS(124), .CSR_NS(5),
        .BURST_RAS_NS(10), .BURST_RP_NS(5), .BURST_LEN(B)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sr_enter_req(enter), .sr_exit_req(exitr),
        .arb_req(arb_req), .arb_gnt(gnt), .ras_n(ras_n), .cas_n(cas_n),
        .busy(busy), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        bit    ras;
        bit    cas;
        bit    bsy;
        bit    rdy;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    bit   cur_self = 1'b0;
    bit   mode_self = 1'b0;
    bit   pend = 1'b0;

    function automatic exp_t mk(bit r, bit c, bit b, bit y, string t);
        exp_t e;
        e.ras = r; e.cas = c; e.bsy = b; e.rdy = y; e.tag = t;
        return e;
    endfunction

    task automatic push_n(input exp_t e, input int n);
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic push_burst();
        for (int i = 0; i < B; i++) begin
            push_n(mk(1, 0, 1, 0, "R3"), CSR);
            push_n(mk(0, 0, 1, 0, "R3"), RASC);
            push_n(mk(1, 1, 1, 0, "R3"), RPC);
        end
    endtask

    initial cur = mk(1, 1, 0, 0, "R1");

    // Advance the expected timeline at each clock edge from the sampled inputs.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            q.delete();
            mode_self = 1'b0;
            pend = 1'b0;
            cur = mk(1, 1, 0, 0, "R1");
            cur_self = 1'b0;
        end else begin
            if (q.size() == 0 && !mode_self && !cur.rdy && enter && gnt) begin
                push_burst();                              // R2: starts next cycle
                push_n(mk(1, 0, 1, 0, "R4"), CSR);
                push_n(mk(0, 0, 1, 0, "R5"), HOLD);
                mode_self = 1'b1;
            end else if (cur_self && (pend || exitr)) begin
                push_n(mk(1, 1, 1, 0, "R7"), PRECH);
                push_burst();
                q.push_back(mk(1, 1, 0, 1, "R8"));
                mode_self = 1'b0;
                pend = 1'b0;
            end else if (mode_self && exitr) begin
                pend = 1'b1;                               // R5: early exit latched
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                cur_self = 1'b0;
            end else if (mode_self) begin
                cur = mk(0, 0, 1, 0, "R6");
                cur_self = 1'b1;
            end else begin
                cur = mk(1, 1, 0, 0, "R10");
                cur_self = 1'b0;
            end
        end
    end

    // Compare outputs with the model mid-cycle.
    always @(negedge clk) begin
        if (started && !done_flag) begin
            bit exp_arb;
            exp_arb = cur.bsy || (!cur.bsy && !cur.rdy && enter && rst_n);
            check(ras_n == cur.ras, cur.tag, "ras_n", ras_n, cur.ras);
            check(cas_n == cur.cas, cur.tag, "cas_n", cas_n, cur.cas);
            check(ready == cur.rdy, cur.tag, "ready", ready, cur.rdy);
            check(arb_req == exp_arb, cur.tag, "arb_req", arb_req, exp_arb);
            check(busy == cur.bsy, "R9", "busy", busy, cur.bsy);
        end
    end

    // ---------------- port monitors ----------------
    bit prev_ras = 1'b1, prev_busy = 1'b0, meas_pre = 1'b0;
    int falls = 0, low_run = 0, hi_run = 0;
    int exp_len = 0;

    always @(negedge clk) begin
        if (started && rst_n && !done_flag) begin
            if (busy && !prev_busy) falls = 0;
            if (!ras_n && prev_ras) falls++;
            if (!ras_n) low_run++;
            if (ras_n && !prev_ras) begin
                if (low_run >= HOLD) begin
                    check(falls - 1 == B, "R3", "pre-entry pulses", falls - 1, B);
                    if (exp_len > 0)
                        check(low_run == exp_len, "R5", "low hold length", low_run, exp_len);
                    else
                        check(low_run > HOLD, "R5", "low hold length", low_run, HOLD + 1);
                    check(cas_n == 1'b1, "R7", "cas rises with ras", cas_n, 1);
                    meas_pre = 1'b1;
                    hi_run = 0;
                    falls = 0;
                end
                low_run = 0;
            end
            if (meas_pre) begin
                if (ras_n && cas_n) hi_run++;
                else if (!cas_n) begin
                    check(hi_run == PRECH, "R7", "precharge cycles", hi_run, PRECH);
                    meas_pre = 1'b0;
                end
            end
            if (ready) check(falls == B, "R8", "post-exit pulses", falls, B);
            prev_ras = ras_n;
            prev_busy = busy;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
        #1;
    endtask

    initial begin
        cyc(3);
        // R1: reset values seen at the ports
        check(ras_n && cas_n, "R1", "strobes in reset", {ras_n, cas_n}, 3);
        check(!busy && !ready && !arb_req, "R1", "status in reset", {busy, ready, arb_req}, 0);
        rst_n = 1'b1;
        cyc(2);

        // R10: exit request while idle is ignored
        exitr = 1'b1; cyc(1); exitr = 1'b0; cyc(3);
        check(!busy && ras_n && cas_n, "R10", "idle after stray exit", busy, 0);

        // Round 1: delayed grant, early exit request
        exp_len = HOLD + 1;
        enter = 1'b1;
        cyc(10);
        check(arb_req && ras_n && cas_n && !busy, "R2", "waiting for grant", {arb_req, ras_n, cas_n}, 3'b111);
        gnt = 1'b1; cyc(1); gnt = 1'b0; enter = 1'b0;
        cyc(100);
        exitr = 1'b1; cyc(1); exitr = 1'b0;
        cyc(5);
        enter = 1'b1; gnt = 1'b1; cyc(1); enter = 1'b0; gnt = 1'b0;
        cyc(3);
        check(busy && !ready, "R10", "enter ignored while busy", busy, 1);
        wait_ready();
        cyc(20);

        // Round 2: immediate grant, late exit, stray exit during precharge
        exp_len = 0;
        enter = 1'b1; gnt = 1'b1; cyc(1); enter = 1'b0; gnt = 1'b0;
        cyc(8 * B + HOLD + 300);
        exitr = 1'b1; cyc(1); exitr = 1'b0;
        cyc(3);
        exitr = 1'b1; cyc(1); exitr = 1'b0;
        wait_ready();
        cyc(1);
        check(!busy && !ready, "R8", "released after ready", {busy, ready}, 0);
        cyc(20);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        check(1'b0, "WDG", "watchdog expired", i_dummy(), 0);
        finish_run();
    end

    function automatic int i_dummy();
        return 1;
    endfunction

endmodule